// File: doc/BRIEF.md
# Speculative Result Rename Buffer

This block holds the results of instructions that have executed but not yet retired, and only moves them into a 32-register architected file when the completion logic says so. Each instruction that writes a register takes one buffer slot at dispatch. The slot index is a tag that travels with the instruction. The execution unit later writes its result into that slot. Results therefore stay speculative until retirement. Two in-flight instructions with the same destination each get their own slot, so neither waits for the other.

Slots form a circular queue. Dispatch takes slots at the tail, and retirement frees the oldest slot at the head, one per cycle. Operand lookups search the queue for the newest pending writer of the requested register. When no slot is pending for it, the lookup falls back to the architected file. A flush throws away everything not yet retired. Dispatch uses a valid/ready handshake. A slot is taken only in a cycle where `alloc_valid` and `alloc_ready` are both high. While `alloc_ready` is low, the dispatcher must hold its request. Write-back, retire and flush are plain pulses with no back-pressure.

Top module: `rename_buffer`

## Requirements
- R1: After reset the queue is empty and `alloc_ready` is 1. Every architected register reads 0. Every lookup reports renamed=0, ready=1 and data 0.
- R2: A dispatch handshake takes the slot whose index is shown on `alloc_tag` in that cycle. Slot indices are handed out in the order 0, 1, …, DEPTH-1 and then wrap to 0.
- R3: A write-back to an allocated slot stores `wb_data` and marks that slot ready from the next cycle. A write-back whose tag names an unallocated slot has no effect, so a later allocation of that slot still reads not ready.
- R4: A `retire` pulse acts only when the oldest slot holds a ready result. It copies that value into the slot's architected register and frees the slot, both visible from the next cycle. A pulse that finds the oldest slot empty or not ready is ignored. At most one slot retires per cycle, oldest first.
- R5: `alloc_ready` is 0 while all DEPTH slots are held. A retirement on a full queue frees a slot that can be allocated only from the following cycle.
- R6: A lookup of a register with pending slots reports renamed=1. It reports the tag of the youngest such slot, ready equal to that slot's ready state, and that slot's data when ready. Each source port looks up independently.
- R7: A lookup of a register with no pending slot reports renamed=0, ready=1 and the architected value.
- R8: A `flush` discards every unretired slot and leaves architected registers untouched. `alloc_ready` is 0 during the flush cycle. A retirement accepted in the same cycle as the flush still completes.
- R9: While slots are free, a new allocation is accepted in every consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_dest | input | 5 | Architected destination register of the dispatched instruction |
| alloc_tag | output | TAG_W | Slot index granted on a handshake |
| wb_valid | input | 1 | Execution result is present |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| retire | input | 1 | Completion logic retires the oldest instruction |
| flush | input | 1 | Discard all unretired slots |
| src_reg | input | NUM_SRC*5 | Register looked up by each source port |
| src_data | output | NUM_SRC*DATA_W | Operand value per source port |
| src_renamed | output | NUM_SRC | A pending slot exists for the register |
| src_ready | output | NUM_SRC | Operand value is available |
| src_tag | output | NUM_SRC*TAG_W | Youngest pending slot for the register |

## Verification
The bench builds the block with DEPTH=4, DATA_W=16 and NUM_SRC=2. With the shallow queue, the full condition is reached after four back-to-back dispatches. Pointer wrap is reached within a handful of retirements, and a flush that leaves the head in mid-ring follows naturally. The 16-bit data keeps the table rows short. The second source port is used to confirm that two lookups in the same cycle return different slots.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int ARCH_REGS = 32;
  localparam int AREG_W    = $clog2(ARCH_REGS);
  typedef logic [AREG_W-1:0] areg_t;
endpackage

// File: rtl/rb_queue_ctl.sv
module rb_queue_ctl #(
  parameter int DEPTH = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] head_nx;
  assign head_nx = commit_fire ? step(head) : head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= head_nx;
      tail  <= head_nx;
      count <= '0;
    end else begin
      head <= head_nx;
      if (alloc_fire) tail <= step(tail);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r4_head_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> head == step($past(head)));

  a_r2_tail_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !flush) |=> tail == step($past(tail)));

  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && tail == head));
endmodule

// File: rtl/rb_entries.sv
module rb_entries
  import rb_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_fire,
  input  logic [PTR_W-1:0]              tail,
  input  areg_t                         alloc_dest,
  input  logic                          wb_valid,
  input  logic [PTR_W-1:0]              wb_tag,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic                          commit_fire,
  input  logic [PTR_W-1:0]              head,
  input  logic                          flush,
  output logic [DEPTH-1:0]              slot_valid,
  output logic [DEPTH-1:0]              slot_done,
  output logic [DEPTH-1:0][AREG_W-1:0]  slot_dest,
  output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, fill, free;
    assign take = alloc_fire && (tail == PTR_W'(i));
    assign fill = wb_valid && (wb_tag == PTR_W'(i)) && slot_valid[i] && !flush;
    assign free = commit_fire && (head == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[i] <= 1'b0;
        slot_done[i]  <= 1'b0;
        slot_dest[i]  <= '0;
        slot_data[i]  <= '0;
      end else begin
        if (flush || free) begin
          slot_valid[i] <= 1'b0;
          slot_done[i]  <= 1'b0;
        end else if (take) begin
          slot_valid[i] <= 1'b1;
          slot_done[i]  <= 1'b0;
          slot_dest[i]  <= alloc_dest;
        end else if (fill) begin
          slot_done[i]  <= 1'b1;
        end
        if (fill) slot_data[i] <= wb_data;
      end
    end

    a_r3_ready_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_done[i]) |-> $past(wb_valid && wb_tag == PTR_W'(i)));
  end

  a_r8_flush_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> slot_valid == '0);
endmodule

// File: rtl/rb_arch_rf.sv
module rb_arch_rf
  import rb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  areg_t                             waddr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [NUM_SRC-1:0][AREG_W-1:0]    raddr,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] regs [ARCH_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++) regs[r] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
    assign rdata[s] = regs[raddr[s]];
  end
endmodule

// File: rtl/rb_lookup.sv
module rb_lookup
  import rb_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]              head,
  input  logic [DEPTH-1:0]              slot_valid,
  input  logic [DEPTH-1:0]              slot_done,
  input  logic [DEPTH-1:0][AREG_W-1:0]  slot_dest,
  input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
  input  areg_t                         reg_idx,
  input  logic [DATA_W-1:0]             arch_val,
  output logic                          hit,
  output logic                          ready,
  output logic [PTR_W-1:0]              tag,
  output logic [DATA_W-1:0]             data
);
  logic [PTR_W-1:0] pick;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W:0] idx;
      idx = {1'b0, head} + (PTR_W + 1)'(k);
      if (idx >= (PTR_W + 1)'(DEPTH)) idx = idx - (PTR_W + 1)'(DEPTH);
      if (slot_valid[idx[PTR_W-1:0]] && slot_dest[idx[PTR_W-1:0]] == reg_idx) begin
        hit  = 1'b1;
        pick = idx[PTR_W-1:0];
      end
    end
  end

  assign tag   = pick;
  assign ready = hit ? slot_done[pick] : 1'b1;
  assign data  = hit ? slot_data[pick] : arch_val;
endmodule

// File: rtl/rename_buffer.sv
module rename_buffer
  import rb_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 2,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  output logic                        alloc_ready,
  input  logic [AREG_W-1:0]           alloc_dest,
  output logic [TAG_W-1:0]            alloc_tag,
  input  logic                        wb_valid,
  input  logic [TAG_W-1:0]            wb_tag,
  input  logic [DATA_W-1:0]           wb_data,
  input  logic                        retire,
  input  logic                        flush,
  input  logic [NUM_SRC*AREG_W-1:0]   src_reg,
  output logic [NUM_SRC*DATA_W-1:0]   src_data,
  output logic [NUM_SRC-1:0]          src_renamed,
  output logic [NUM_SRC-1:0]          src_ready,
  output logic [NUM_SRC*TAG_W-1:0]    src_tag
);
  logic [TAG_W-1:0]                 head, tail;
  logic [CNT_W-1:0]                 count;
  logic                             alloc_fire, commit_fire;
  logic [DEPTH-1:0]                 slot_valid, slot_done;
  logic [DEPTH-1:0][AREG_W-1:0]     slot_dest;
  logic [DEPTH-1:0][DATA_W-1:0]     slot_data;
  logic [NUM_SRC-1:0][AREG_W-1:0]   raddr;
  logic [NUM_SRC-1:0][DATA_W-1:0]   arch_val;

  assign alloc_ready = (count != CNT_W'(DEPTH)) && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign commit_fire = retire && slot_valid[head] && slot_done[head];

  rb_queue_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .commit_fire(commit_fire),
    .flush(flush), .head(head), .tail(tail), .count(count)
  );

  rb_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ent (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail(tail),
    .alloc_dest(alloc_dest), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .commit_fire(commit_fire), .head(head), .flush(flush),
    .slot_valid(slot_valid), .slot_done(slot_done), .slot_dest(slot_dest),
    .slot_data(slot_data)
  );

  rb_arch_rf #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_arf (
    .clk(clk), .rst_n(rst_n), .we(commit_fire), .waddr(slot_dest[head]),
    .wdata(slot_data[head]), .raddr(raddr), .rdata(arch_val)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign raddr[s] = src_reg[s*AREG_W +: AREG_W];
    rb_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lk (
      .head(head), .slot_valid(slot_valid), .slot_done(slot_done),
      .slot_dest(slot_dest), .slot_data(slot_data), .reg_idx(raddr[s]),
      .arch_val(arch_val[s]), .hit(src_renamed[s]), .ready(src_ready[s]),
      .tag(src_tag[s*TAG_W +: TAG_W]), .data(src_data[s*DATA_W +: DATA_W])
    );
  end

  a_r4_retire_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !slot_done[head]) |=> head == $past(head));
endmodule

// File: tb/rename_buffer_bench.sv
module rename_buffer_bench;
  localparam int DEPTH = 4, DW = 16, NS = 2, TW = 2;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready, wb_valid = 0, retire = 0, flush = 0;
  logic [4:0] alloc_dest = 0, s0 = 0, s1 = 0;
  logic [TW-1:0] alloc_tag, wb_tag = 0;
  logic [DW-1:0] wb_data = 0;
  logic [NS*DW-1:0] src_data;
  logic [NS-1:0] src_renamed, src_ready;
  logic [NS*TW-1:0] src_tag;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rename_buffer #(.DEPTH(DEPTH), .DATA_W(DW), .NUM_SRC(NS)) u_rename_buffer (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .retire(retire), .flush(flush),
    .src_reg({s1, s0}), .src_data(src_data), .src_renamed(src_renamed),
    .src_ready(src_ready), .src_tag(src_tag)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // row: op[44:42] reg[41:37] tag[36:34] data[33:18] ren[17] rdy[16] exp[15:0]
  // op: 0 idle, 1 dispatch, 2 write-back, 3 retire, 4 flush
  localparam logic [44:0] TBL [16] = '{
    {3'd1, 5'd5, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R2 slot0
    {3'd1, 5'd5, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R9 slot1 same dest
    {3'd2, 5'd5, 3'd0, 16'h1111, 1'b1, 1'b0, 16'h0000},  // R6 youngest not ready
    {3'd2, 5'd5, 3'd1, 16'h2222, 1'b1, 1'b1, 16'h2222},  // R3
    {3'd3, 5'd5, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h2222},  // R4 older retires
    {3'd3, 5'd5, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h2222},  // R4/R7
    {3'd0, 5'd9, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h0000},  // R7
    {3'd1, 5'd9, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // slot2
    {3'd3, 5'd9, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R4 ignored
    {3'd2, 5'd9, 3'd3, 16'hDEAD, 1'b1, 1'b0, 16'h0000},  // R3 unallocated
    {3'd1, 5'd7, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // R3 slot3 not ready
    {3'd0, 5'd7, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},
    {3'd4, 5'd9, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h0000},  // R8
    {3'd0, 5'd5, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h2222},  // R8 arch kept
    {3'd1, 5'd1, 3'd0, 16'h0000, 1'b1, 1'b0, 16'h0000},  // slot2 after flush
    {3'd2, 5'd1, 3'd2, 16'h3333, 1'b1, 1'b1, 16'h3333}   // R3/R6
  };

  task automatic run_row(input int n, input logic [44:0] r);
    @(negedge clk);
    case (r[44:42])
      3'd1: begin alloc_valid = 1; alloc_dest = r[41:37]; end
      3'd2: begin wb_valid = 1; wb_tag = r[35:34]; wb_data = r[33:18]; end
      3'd3: retire = 1;
      3'd4: flush = 1;
      default: ;
    endcase
    @(negedge clk);
    alloc_valid = 0; wb_valid = 0; retire = 0; flush = 0;
    s0 = r[41:37];
    #1;
    chk($sformatf("R6/R7 row%0d renamed", n), 32'(src_renamed[0]), 32'(r[17]));
    chk($sformatf("R3/R6 row%0d ready", n), 32'(src_ready[0]), 32'(r[16]));
    if (r[16]) chk($sformatf("R4/R7 row%0d data", n), 32'(src_data[DW-1:0]), 32'(r[15:0]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    s0 = 0; #1;
    chk("R1 ready", 32'(alloc_ready), 1);
    chk("R1 renamed", 32'(src_renamed[0]), 0);
    chk("R1 data", 32'(src_data[DW-1:0]), 0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) run_row(i, TBL[i]);

    // reset, then fill the queue back to back
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      alloc_valid = 1; alloc_dest = 5'(10 + i);
      #1;
      chk("R9 ready each cycle", 32'(alloc_ready), 1);
      chk("R2 tag order", 32'(alloc_tag), 32'(i));
    end
    @(negedge clk); alloc_valid = 0; #1;
    chk("R5 full", 32'(alloc_ready), 0);
    wb_valid = 1; wb_tag = 0; wb_data = 16'h0A0A;
    @(negedge clk); wb_valid = 0;
    retire = 1; alloc_valid = 1; alloc_dest = 14; #1;
    chk("R5 full during retire", 32'(alloc_ready), 0);
    @(negedge clk); retire = 0; #1;
    chk("R5 freed next cycle", 32'(alloc_ready), 1);
    chk("R2 wrap", 32'(alloc_tag), 0);
    s0 = 10; #1;
    chk("R4 committed renamed", 32'(src_renamed[0]), 0);
    chk("R4 committed data", 32'(src_data[DW-1:0]), 32'h0A0A);
    @(negedge clk); alloc_valid = 0;
    s0 = 11; s1 = 14; #1;
    chk("R6 port1 tag", 32'(src_tag[2*TW-1:TW]), 0);
    chk("R6 port0 tag", 32'(src_tag[TW-1:0]), 1);
    wb_valid = 1; wb_tag = 1; wb_data = 16'h0ABC;
    @(negedge clk); wb_valid = 0; retire = 1; flush = 1; #1;
    chk("R8 no dispatch in flush", 32'(alloc_ready), 0);
    @(negedge clk); retire = 0; flush = 0;
    s0 = 11; s1 = 12; #1;
    chk("R8 retire kept renamed", 32'(src_renamed[0]), 0);
    chk("R8 retire kept data", 32'(src_data[DW-1:0]), 32'h0ABC);
    chk("R8 dropped renamed", 32'(src_renamed[1]), 0);
    chk("R8 dropped data", 32'(src_data[2*DW-1:DW]), 0);
    chk("R8 empty ready", 32'(alloc_ready), 1);
    chk("R8 tail at head", 32'(alloc_tag), 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule